// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 8-bit-byte timer/counters of the classic 8051 kind. Each one can count machine cycles, where a machine cycle is a fixed number of system clocks (two by default). It can instead count falling edges on its own external input, which is sampled once per machine cycle. A small register port carries the counts and the mode settings. Each timer has a low count byte, a high count byte and a configuration byte. A shared flag byte holds the two overflow flags. All register reads are combinational.

Each timer has five working modes:

- a 13-bit count, in which the high byte is fed by a 5-bit prescaler held in the low byte;
- a full 16-bit count;
- an 8-bit count that reloads from the high byte;
- a split mode, in which timer 0 becomes two independent 8-bit counters and timer 1 stops;
- an 8-bit pulse-width mode with a 256-count period.

Each timer drives one output pin. Outside pulse-width mode the pin can toggle on every overflow. Timer 1 also gives a one-cycle rate strobe on each of its overflows, and this strobe still works while timer 0 is split.

Top module: `twin_cycle_timer`

## Requirements
- R1: In timer function a running timer (config bit 4 = 1) advances once per machine cycle (CLKS_PER_MC = 2 clocks), so a run window of 2N clocks adds exactly N. With config bit 4 = 0 the count holds.
- R2: In counter function (config bit 3 = 1), the count advances once for each machine-cycle sample of ext_in that reads 0 after a sample that read 1. An input that toggles every clock is sampled in the same phase each time and adds at most one.
- R3: Mode code 0 counts the 13-bit value {high byte, low byte bits 4:0}. It overflows on the wrap from all ones, and low byte bits 7:5 are left untouched.
- R4: Mode code 1 counts the 16-bit value {high byte, low byte} and overflows on the wrap from FFFFh to 0000h.
- R5: Mode code 2 counts the low byte only. When the low byte wraps from FFh it is loaded from the high byte and an overflow is signalled.
- R6: With timer 0 in mode code 3, timer 0's low byte counts under timer 0's own run and source bits and sets flag 0. Timer 0's high byte counts machine cycles under timer 1's run bit and sets flag 1. Timer 1 in mode code 3 holds its count.
- R7: rate_tick pulses for one clock on every timer 1 overflow. While timer 0 is in mode code 3, a timer 1 overflow does not set flag 1; otherwise it does.
- R8: In mode code 6 the low byte counts freely with a 256-count period. The pin reads 1 while the low byte is below a compare value and 0 otherwise. The compare value is copied from the high byte only when the low byte wraps from FFh.
- R9: Each pin resets to 1. With config bit 5 = 1 it inverts on every overflow of its timer's main count; with bit 5 = 0 it stays put.
- R10: Flag k (flag byte bit k) sets on each overflow of its source. A write to the flag byte clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A set in the same cycle wins.
- R11: Register map: address 0/1 = timer 0 low/high, 2/3 = timer 1 low/high, 4/5 = timer 0/1 config {bit5 toggle enable, bit4 run, bit3 counter select, bits2:0 mode}, 6 = flags. After reset all registers read 0 and both pins read 1.
- R12: Mode codes 4, 5 and 7 are reserved. A timer set to one of them holds its count and raises no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, shared by read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ext_in | input | 2 | External count inputs, bit i for timer i |
| ovf_flag | output | 2 | Overflow flags 1:0 |
| pin_out | output | 2 | Toggle / pulse-width outputs, bit i for timer i |
| rate_tick | output | 1 | One-clock strobe on each timer 1 overflow |

## Verification
The bench loads counts close to each wrap point and checks the following:

- **13-bit mode.** A design that carries into the high byte from low-byte bit 7 instead of bit 4 gives the wrong high byte. A design that clears bits 7:5 also fails.
- **Reload mode.** A design that reloads to zero, or that does not reload, ends on the wrong low byte.
- **Counter function.** An input toggled every clock must add at most one count. A detector that samples every clock counts about twenty.
- **Split mode.** A design that routes the two halves to the wrong run bits or flags moves the wrong byte or sets the wrong flag.
- **Pulse-width compare.** A design that tracks the high byte at once, instead of at the wrap, changes the pin in the middle of a period.
- **Flag write.** A flag byte that treats a written 1 as a set, or clears every flag on any write, is caught.
- **Reserved codes.** A reserved mode that counts is caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        MODE_13B    = 3'd0,
        MODE_16B    = 3'd1,
        MODE_RELOAD = 3'd2,
        MODE_SPLIT  = 3'd3,
        MODE_RSV4   = 3'd4,
        MODE_RSV5   = 3'd5,
        MODE_PWM    = 3'd6,
        MODE_RSV7   = 3'd7
    } tmr_mode_e;

    // config byte bits 5:0
    typedef struct packed {
        logic      tog_en;
        logic      run;
        logic      ext_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;

    localparam int CFG_W = $bits(tmr_cfg_t);

    localparam logic [ADDR_W-1:0] ADDR_CFG0  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd6;

    function automatic logic [ADDR_W-1:0] lo_addr(input int idx);
        return ADDR_W'(2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int idx);
        return ADDR_W'(2 * idx + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
        return ADDR_W'(32'(ADDR_CFG0) + idx);
    endfunction

endpackage

// File: rtl/tmr_cycle_gen.sv
module tmr_cycle_gen #(
    parameter int CLKS_PER_MC = 2
) (
    input  logic clk,
    input  logic rst,
    output logic mc_en
);
    localparam int CNT_W = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_MC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cnt_q == LAST) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign mc_en = (cnt_q == LAST);

    generate
        if (CLKS_PER_MC > 1) begin : g_gap
            // R1: machine-cycle strobes are never back to back
            a_r1_mc_gap: assert property (@(posedge clk) disable iff (rst)
                mc_en |=> !mc_en);
        end
    endgenerate
endmodule

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic mc_en,
    input  logic pin,
    output logic fall
);
    logic samp_q;

    always_ff @(posedge clk) begin
        if (rst)        samp_q <= 1'b0;
        else if (mc_en) samp_q <= pin;
    end

    // previous sample high, this sample low
    assign fall = mc_en & samp_q & ~pin;
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
    import tmr_pkg::*;
#(
    parameter int PRESCALE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  tmr_mode_e         mode,
    input  logic              tick,
    input  logic              hi_tick,
    input  logic              tog_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] tl,
    output logic [BYTE_W-1:0] th,
    output logic              ovf_lo,
    output logic              ovf_hi,
    output logic              pin
);
    localparam int NARROW_W = BYTE_W + PRESCALE_W;

    logic [BYTE_W-1:0] tl_q, th_q, tl_n, th_n, cmp_q;
    logic              tog_q, wrap_pwm;
    logic [NARROW_W-1:0] narrow_n;

    always_comb begin
        tl_n     = tl_q;
        th_n     = th_q;
        ovf_lo   = 1'b0;
        ovf_hi   = 1'b0;
        wrap_pwm = 1'b0;
        narrow_n = {th_q, tl_q[PRESCALE_W-1:0]} + 1'b1;
        case (mode)
            MODE_13B: if (tick) begin
                th_n                 = narrow_n[NARROW_W-1:PRESCALE_W];
                tl_n[PRESCALE_W-1:0] = narrow_n[PRESCALE_W-1:0];
                ovf_lo               = &{th_q, tl_q[PRESCALE_W-1:0]};
            end
            MODE_16B: if (tick) begin
                {th_n, tl_n} = {th_q, tl_q} + 1'b1;
                ovf_lo       = &{th_q, tl_q};
            end
            MODE_RELOAD: if (tick) begin
                ovf_lo = &tl_q;
                tl_n   = (&tl_q) ? th_q : tl_q + 1'b1;
            end
            MODE_SPLIT: begin
                if (tick) begin
                    tl_n   = tl_q + 1'b1;
                    ovf_lo = &tl_q;
                end
                if (hi_tick) begin
                    th_n   = th_q + 1'b1;
                    ovf_hi = &th_q;
                end
            end
            MODE_PWM: if (tick) begin
                tl_n     = tl_q + 1'b1;
                ovf_lo   = &tl_q;
                wrap_pwm = &tl_q;
            end
            default: ;
        endcase
        if (wr_lo) tl_n = wdata;
        if (wr_hi) th_n = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tl_q  <= '0;
            th_q  <= '0;
            cmp_q <= '0;
            tog_q <= 1'b1;
        end else begin
            tl_q <= tl_n;
            th_q <= th_n;
            if (wrap_pwm)          cmp_q <= th_q;
            if (ovf_lo && tog_en)  tog_q <= ~tog_q;
        end
    end

    assign tl  = tl_q;
    assign th  = th_q;
    assign pin = (mode == MODE_PWM) ? (tl_q < cmp_q) : tog_q;

    // R5: a wrap in reload mode lands on the high byte
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RELOAD && tick && tl_q == '1 && !wr_lo && !wr_hi)
        |=> tl_q == $past(th_q));

    // R8: compare value changes only at a period start
    a_r8_cmp_hold: assert property (@(posedge clk) disable iff (rst)
        !(mode == MODE_PWM && tick && tl_q == '1) |=> $stable(cmp_q));

    // R9: the toggle state moves only after an overflow
    a_r9_pin_hold: assert property (@(posedge clk) disable iff (rst)
        !ovf_lo |=> $stable(tog_q));
endmodule

// File: rtl/twin_cycle_timer.sv
module twin_cycle_timer
    import tmr_pkg::*;
#(
    parameter int CLKS_PER_MC = 2,
    parameter int PRESCALE_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [1:0]        ext_in,
    output logic [1:0]        ovf_flag,
    output logic [1:0]        pin_out,
    output logic              rate_tick
);
    localparam int N_TMR = 2;

    logic                         mc_en;
    tmr_cfg_t                     cfg_q [N_TMR];
    logic [N_TMR-1:0][BYTE_W-1:0] tl_w, th_w;
    logic [N_TMR-1:0]             fall, tick, hi_tick, wr_lo, wr_hi;
    logic [N_TMR-1:0]             ovf_lo, ovf_hi, flag_q, flag_set;
    logic                         split0, wr_flags;

    tmr_cycle_gen #(.CLKS_PER_MC(CLKS_PER_MC)) u_cycle (
        .clk   (clk),
        .rst   (rst),
        .mc_en (mc_en)
    );

    assign split0   = (cfg_q[0].mode == MODE_SPLIT);
    assign wr_flags = reg_wr && (reg_addr == ADDR_FLAGS);

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            logic halted;
            if (i == 0) begin : g_first
                assign halted     = 1'b0;
                assign hi_tick[i] = cfg_q[1].run & mc_en;
            end else begin : g_other
                assign halted     = (cfg_q[i].mode == MODE_SPLIT);
                assign hi_tick[i] = 1'b0;
            end

            tmr_fall_detect u_edge (
                .clk   (clk),
                .rst   (rst),
                .mc_en (mc_en),
                .pin   (ext_in[i]),
                .fall  (fall[i])
            );

            assign tick[i]  = cfg_q[i].run & ~halted &
                              (cfg_q[i].ext_sel ? fall[i] : mc_en);
            assign wr_lo[i] = reg_wr && (reg_addr == lo_addr(i));
            assign wr_hi[i] = reg_wr && (reg_addr == hi_addr(i));

            tmr_count_unit #(.PRESCALE_W(PRESCALE_W)) u_count (
                .clk     (clk),
                .rst     (rst),
                .mode    (cfg_q[i].mode),
                .tick    (tick[i]),
                .hi_tick (hi_tick[i]),
                .tog_en  (cfg_q[i].tog_en),
                .wr_lo   (wr_lo[i]),
                .wr_hi   (wr_hi[i]),
                .wdata   (reg_wdata),
                .tl      (tl_w[i]),
                .th      (th_w[i]),
                .ovf_lo  (ovf_lo[i]),
                .ovf_hi  (ovf_hi[i]),
                .pin     (pin_out[i])
            );
        end
    endgenerate

    assign flag_set[0] = ovf_lo[0];
    assign flag_set[1] = split0 ? ovf_hi[0] : ovf_lo[1];
    assign rate_tick   = ovf_lo[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            for (int k = 0; k < N_TMR; k++) cfg_q[k] <= '0;
        end else begin
            flag_q <= (wr_flags ? (flag_q & reg_wdata[N_TMR-1:0]) : flag_q)
                      | flag_set;
            for (int k = 0; k < N_TMR; k++)
                if (reg_wr && reg_addr == cfg_addr(k))
                    cfg_q[k] <= tmr_cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            3'd0: reg_rdata = tl_w[0];
            3'd1: reg_rdata = th_w[0];
            3'd2: reg_rdata = tl_w[1];
            3'd3: reg_rdata = th_w[1];
            3'd4: reg_rdata = BYTE_W'(cfg_q[0]);
            3'd5: reg_rdata = BYTE_W'(cfg_q[1]);
            3'd6: reg_rdata = BYTE_W'(flag_q);
            default: reg_rdata = '0;
        endcase
    end

    assign ovf_flag = flag_q;

    // R10: flag 0 only rises after an overflow of its source
    a_r10_flag_src: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[0]) |-> $past(ovf_lo[0]));

    // R6: timer 1 in split mode keeps its low byte
    a_r6_t1_halt: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[1].mode == MODE_SPLIT && !wr_lo[1]) |=> $stable(tl_w[1]));

    // R7: with timer 0 split, flag 1 rises only from timer 0's high byte
    a_r7_flag1_src: assert property (@(posedge clk) disable iff (rst)
        (split0 && !ovf_hi[0]) |=> !$rose(flag_q[1]));
endmodule

// File: tb/twin_cycle_timer_bench.sv
module twin_cycle_timer_bench;
    localparam int MC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] ext_in = 2'b11;
    logic [1:0] ovf_flag, pin_out;
    logic       rate_tick;

    int checks = 0;
    int errors = 0;
    int rate_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    twin_cycle_timer u_twin_cycle_timer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_in(ext_in),
        .ovf_flag(ovf_flag), .pin_out(pin_out), .rate_tick(rate_tick)
    );

    always @(negedge clk) if (!rst && rate_tick) rate_cnt++;

    // {mode, tl, th, n machine cycles, expected tl, expected th, expected flag0}
    localparam int NV = 9;
    localparam logic [43:0] VEC [NV] = '{
        {3'd1, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 1'b1},
        {3'd1, 8'h10, 8'h12, 8'd5, 8'h15, 8'h12, 1'b0},
        {3'd0, 8'hFE, 8'hFF, 8'd3, 8'hE1, 8'h00, 1'b1},
        {3'd0, 8'h1F, 8'h05, 8'd1, 8'h00, 8'h06, 1'b0},
        {3'd2, 8'hFE, 8'h80, 8'd4, 8'h82, 8'h80, 1'b1},
        {3'd2, 8'h00, 8'h00, 8'd3, 8'h03, 8'h00, 1'b0},
        {3'd6, 8'hFD, 8'h40, 8'd4, 8'h01, 8'h40, 1'b1},
        {3'd5, 8'h33, 8'h44, 8'd3, 8'h33, 8'h44, 1'b0},
        {3'd7, 8'hFF, 8'hFF, 8'd2, 8'hFF, 8'hFF, 1'b0}
    };

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4 (R1 rate)";
            3'd2: return "R5";
            3'd6: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // runs for exactly n machine cycles (2n clocks with run set)
    task automatic run_mc(input logic [2:0] cfga, input logic [7:0] cfgv, input int n);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = cfga; reg_wdata = cfgv | 8'h10;
        @(posedge clk);
        repeat (MC * n - 1) @(posedge clk);
        @(negedge clk);
        reg_addr = cfga; reg_wdata = cfgv;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        int r0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            check("R11 reset register", d, 0);
        end
        check("R11 reset pins", pin_out, 2'b11);
        check("R11 reset flags", ovf_flag, 0);
        wr(3'd5, 8'h2A);
        rd(3'd5, d);
        check("R11 config readback", d, 8'h2A);
        wr(3'd5, 8'h00);

        // R1 stopped timer holds
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h01);
        repeat (10) @(posedge clk);
        rd(3'd0, d);
        check("R1 stopped count holds", d, 0);

        // vector table on timer 0
        for (int v = 0; v < NV; v++) begin
            logic [2:0] m;
            m = VEC[v][43:41];
            wr(3'd4, {5'd0, m});
            wr(3'd0, VEC[v][40:33]);
            wr(3'd1, VEC[v][32:25]);
            wr(3'd6, 8'h00);
            run_mc(3'd4, {5'd0, m}, int'(VEC[v][24:17]));
            rd(3'd0, d);
            check({mode_tag(m), " low byte"}, d, VEC[v][16:9]);
            rd(3'd1, d);
            check({mode_tag(m), " high byte"}, d, VEC[v][8:1]);
            check({mode_tag(m), " flag0"}, ovf_flag[0], VEC[v][0]);
        end

        // R9 toggle disabled: pin 0 still 1 after several overflows
        wr(3'd4, 8'h01);
        check("R9 pin held without toggle enable", pin_out[0], 1);

        // R10 flag write semantics
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        run_mc(3'd4, 8'h01, 1);
        check("R10 flag set on wrap", ovf_flag[0], 1);
        wr(3'd6, 8'h01);
        check("R10 written 1 keeps flag", ovf_flag[0], 1);
        wr(3'd6, 8'h00);
        check("R10 written 0 clears flag", ovf_flag[0], 0);

        // R9 toggle on timer 1, reload mode
        wr(3'd5, 8'h22); wr(3'd2, 8'hFE); wr(3'd3, 8'hFE);
        check("R9 pin 1 before first overflow", pin_out[1], 1);
        run_mc(3'd5, 8'h22, 2);
        check("R9 pin inverts on overflow", pin_out[1], 0);
        check("R10 flag1 from timer 1", ovf_flag[1], 1);
        run_mc(3'd5, 8'h22, 2);
        check("R9 pin inverts again", pin_out[1], 1);
        wr(3'd5, 8'h02);

        // R2 counter function
        wr(3'd4, 8'h09); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        ext_in[0] = 1'b1;
        repeat (4) @(posedge clk);
        wr(3'd4, 8'h19);
        for (int p = 0; p < 3; p++) begin
            @(negedge clk) ext_in[0] = 1'b1;
            repeat (4) @(negedge clk);
            ext_in[0] = 1'b0;
            repeat (4) @(negedge clk);
        end
        ext_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        wr(3'd4, 8'h09);
        rd(3'd0, d);
        check("R2 three slow falling edges", d, 3);
        wr(3'd0, 8'h00);
        repeat (4) @(negedge clk);
        wr(3'd4, 8'h19);
        for (int p = 0; p < 40; p++) begin
            @(negedge clk) ext_in[0] = ~ext_in[0];
        end
        ext_in[0] = 1'b1;
        wr(3'd4, 8'h09);
        rd(3'd0, d);
        check("R2 per-clock toggling counts at most once", (d <= 1) ? 1 : 0, 1);

        // R6 split mode
        wr(3'd6, 8'h00);
        wr(3'd4, 8'h03); wr(3'd0, 8'hFE); wr(3'd1, 8'hFF); wr(3'd2, 8'h05);
        run_mc(3'd5, 8'h03, 2);
        rd(3'd1, d);
        check("R6 high half runs on timer 1 run bit", d, 8'h01);
        rd(3'd0, d);
        check("R6 low half idle", d, 8'hFE);
        rd(3'd2, d);
        check("R6 timer 1 halted", d, 8'h05);
        check("R6 flags after high half wrap", ovf_flag, 2'b10);
        run_mc(3'd4, 8'h03, 2);
        rd(3'd0, d);
        rd(3'd1, d2);
        check("R6 low half wraps", d, 8'h00);
        check("R6 high half held", d2, 8'h01);
        check("R6 flag0 from low half", ovf_flag[0], 1);

        // R7 rate strobe with timer 0 split, then not split
        wr(3'd6, 8'h00);
        wr(3'd5, 8'h02); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        r0 = rate_cnt;
        run_mc(3'd5, 8'h02, 3);
        check("R7 rate strobe count", rate_cnt - r0, 3);
        check("R7 no flag1 while split", ovf_flag[1], 0);
        wr(3'd4, 8'h01);
        run_mc(3'd5, 8'h02, 1);
        check("R7 flag1 when not split", ovf_flag[1], 1);

        // R8 compare latch
        wr(3'd5, 8'h06); wr(3'd2, 8'hFF); wr(3'd3, 8'h03);
        run_mc(3'd5, 8'h06, 1);
        check("R8 below compare high", pin_out[1], 1);
        wr(3'd2, 8'h03);
        check("R8 at compare low", pin_out[1], 0);
        wr(3'd2, 8'h02);
        check("R8 below compare again", pin_out[1], 1);
        wr(3'd3, 8'h00);
        check("R8 compare held within period", pin_out[1], 1);
        run_mc(3'd5, 8'h06, 254);
        rd(3'd2, d);
        check("R8 period wrap", d, 8'h00);
        check("R8 new compare at period start", pin_out[1], 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule